// File: doc/BRIEF.md
# ATA Taskfile Command Decoder

This block is the device-side register file that a host fills in before it starts a disk command. The host writes single bytes into seven registers: features, sector count, three address bytes, device, and command. Each of the features, count and address registers is two bytes deep. A new write pushes the byte already held into a "previous" slot, so the host can supply the high half of a 16-bit field first and then the low half.

A write to the command register starts a decode. The opcode picks the operation, and it also picks whether the address is assembled as a 28-bit or a 48-bit value. If the device-select bit matches the block's strap and the opcode is supported, a one-cycle command-valid pulse comes out. The pulse carries the operation, the full logical block address, the sector count and the features value. A rejected opcode raises the error bit of the status register.

Top module: `tfr_cmd_decoder`

## Requirements
- R1: After reset, every stored byte is zero, status reads 0x00, the command register reads 0x00, cmd_valid is low and dev_reg reads 0xA0. A 48-bit read issued right after reset therefore reports address 0, a count of 65536 and features 0.
- R2: Selects 0 (features), 1 (count), 2 (address low), 3 (address mid) and 4 (address high) each keep two bytes. On a write, the current byte moves into the previous slot and the written byte becomes current.
- R3: For a 48-bit command, bits 47:0 of cmd_lba are hi_prev, mid_prev, lo_prev, hi_cur, mid_cur, lo_cur, from the top down. Writing 0x56,0xEF to low, then 0x34,0xCD to mid, then 0x12,0xAB to high yields 0x123456ABCDEF.
- R4: For a 28-bit command, cmd_lba[27:24] is the device register bits 3:0, cmd_lba[23:0] is hi_cur, mid_cur, lo_cur, and bits 47:28 are zero.
- R5: The opcodes decode as follows. 0x20 is a 28-bit read and 0x24 a 48-bit read. 0x30 is a 28-bit write and 0x34 a 48-bit write. 0xEC is identify. cmd_op encodes read as 1, write as 2 and identify as 3. cmd_ext is 1 only for 0x24 and 0x34.
- R6: A 28-bit command's count is count_cur, with 0 meaning 256. A 48-bit command's count is {count_prev, count_cur}, with 0 meaning 65536. Identify reports a count of 1 and address 0.
- R7: cmd_feat is {feat_prev, feat_cur} for 48-bit commands and {8'h00, feat_cur} otherwise.
- R8: An opcode with the device matching but outside the five supported ones sets status bit 0 and gives no pulse. An accepted command clears that bit.
- R9: A read or write opcode while device bit 6 (LBA mode) is clear is treated as an error (status bit 0 set, no pulse). Identify does not need that bit.
- R10: When device bit 4 differs from dev_strap, a command write gives no pulse and leaves status and the stored bytes unchanged. Only cmd_reg takes the new opcode.
- R11: cmd_valid is high for exactly the one cycle that follows the clock edge at which the command write is sampled.
- R12: dev_reg returns the stored device byte with bits 7 and 5 forced to 1. A write with select 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_strap | input | 1 | Device number this block answers to |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 feat,1 count,2 lo,3 mid,4 hi,5 device,6 command) |
| wr_data | input | 8 | Written byte |
| cmd_valid | output | 1 | One-cycle accepted-command pulse |
| cmd_op | output | 2 | Operation: 1 read, 2 write, 3 identify |
| cmd_ext | output | 1 | 48-bit addressing in use |
| cmd_lba | output | 48 | Assembled logical block address |
| cmd_count | output | 17 | Sector count, 1 to 65536 |
| cmd_feat | output | 16 | Features value |
| dev_reg | output | 8 | Device register readback |
| cmd_reg | output | 8 | Last written opcode |
| status | output | 8 | Status; bit 0 is the error flag |

## Verification
Every result is registered once. A byte written at clock edge N shows in dev_reg or cmd_reg after edge N. A command written at edge N drives cmd_valid, its fields and the status bit from edge N until edge N+1. The bench drives each write half a cycle before the edge and samples at the next falling edge, which is the single cycle where the pulse is due. After an accepted command it samples one more falling edge to confirm the pulse has gone low. Stored bytes can only be seen through a later command, so each check about an ignored write is followed by a command whose decoded fields would show any change.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 3;
  localparam int NUM_FIFO = 5;
  localparam int LBA_W    = 6 * BYTE_W;
  localparam int CNT_W    = 2 * BYTE_W + 1;
  localparam int FEAT_W   = 2 * BYTE_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_FEAT    = 3'd0,
    SEL_COUNT   = 3'd1,
    SEL_LBA_LO  = 3'd2,
    SEL_LBA_MID = 3'd3,
    SEL_LBA_HI  = 3'd4,
    SEL_DEVICE  = 3'd5,
    SEL_CMD     = 3'd6,
    SEL_NONE    = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_IDENT = 2'd3
  } op_e;

  localparam logic [BYTE_W-1:0] OPC_RD_SHORT = 8'h20;
  localparam logic [BYTE_W-1:0] OPC_RD_LONG  = 8'h24;
  localparam logic [BYTE_W-1:0] OPC_WR_SHORT = 8'h30;
  localparam logic [BYTE_W-1:0] OPC_WR_LONG  = 8'h34;
  localparam logic [BYTE_W-1:0] OPC_IDENT    = 8'hEC;

  localparam logic [BYTE_W-1:0] DEV_FIXED_ONES = 8'hA0;
  localparam int DEV_LBA_BIT = 6;
  localparam int DEV_SEL_BIT = 4;

  typedef struct packed {
    logic known;
    op_e  op;
    logic ext;
    logic need_lba;
  } dec_t;

  function automatic dec_t decode_opcode(input logic [BYTE_W-1:0] opc);
    dec_t d;
    d.known    = 1'b1;
    d.op       = OP_NONE;
    d.ext      = 1'b0;
    d.need_lba = 1'b1;
    case (opc)
      OPC_RD_SHORT: d.op = OP_READ;
      OPC_RD_LONG:  begin d.op = OP_READ;  d.ext = 1'b1; end
      OPC_WR_SHORT: d.op = OP_WRITE;
      OPC_WR_LONG:  begin d.op = OP_WRITE; d.ext = 1'b1; end
      OPC_IDENT:    begin d.op = OP_IDENT; d.need_lba = 1'b0; end
      default:      begin d.known = 1'b0;  d.need_lba = 1'b0; end
    endcase
    return d;
  endfunction

  function automatic logic [LBA_W-1:0] lba_long(
      input logic [BYTE_W-1:0] hi_p, input logic [BYTE_W-1:0] mid_p,
      input logic [BYTE_W-1:0] lo_p, input logic [BYTE_W-1:0] hi_c,
      input logic [BYTE_W-1:0] mid_c, input logic [BYTE_W-1:0] lo_c);
    return {hi_p, mid_p, lo_p, hi_c, mid_c, lo_c};
  endfunction

  function automatic logic [LBA_W-1:0] lba_short(
      input logic [3:0] dev_nib, input logic [BYTE_W-1:0] hi_c,
      input logic [BYTE_W-1:0] mid_c, input logic [BYTE_W-1:0] lo_c);
    return {{(LBA_W-4-3*BYTE_W){1'b0}}, dev_nib, hi_c, mid_c, lo_c};
  endfunction

  function automatic logic [CNT_W-1:0] count_short(input logic [BYTE_W-1:0] c);
    logic [CNT_W-1:0] r;
    if (c == '0) r = CNT_W'(1 << BYTE_W);
    else         r = CNT_W'(c);
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] count_long(
      input logic [BYTE_W-1:0] p, input logic [BYTE_W-1:0] c);
    logic [CNT_W-1:0] r;
    if ({p, c} == '0) r = CNT_W'(1 << (2 * BYTE_W));
    else              r = {1'b0, p, c};
    return r;
  endfunction

endpackage

// File: rtl/tfr_byte_fifo.sv
module tfr_byte_fifo #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      prev <= '0;
    end else if (push) begin
      prev <= cur;
      cur  <= din;
    end
  end

endmodule

// File: rtl/tfr_cmd_decode.sv
module tfr_cmd_decode
  import tfr_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  input  logic              dev_lba_mode,
  input  logic              dev_select,
  input  logic              dev_strap,
  output logic              dev_match,
  output logic              accept,
  output logic              reject,
  output op_e               op,
  output logic              ext
);

  dec_t d;

  always_comb begin
    d         = decode_opcode(opcode);
    dev_match = (dev_select == dev_strap);
    op        = d.op;
    ext       = d.ext;
    accept    = dev_match && d.known && (dev_lba_mode || !d.need_lba);
    reject    = dev_match && !(d.known && (dev_lba_mode || !d.need_lba));
  end

endmodule

// File: rtl/tfr_addr_build.sv
module tfr_addr_build
  import tfr_pkg::*;
(
  input  logic [NUM_FIFO-1:0][BYTE_W-1:0] cur,
  input  logic [NUM_FIFO-1:0][BYTE_W-1:0] prev,
  input  logic [3:0]                      dev_nib,
  input  op_e                             op,
  input  logic                            ext,
  output logic [LBA_W-1:0]                lba,
  output logic [CNT_W-1:0]                count,
  output logic [FEAT_W-1:0]               feat
);

  localparam int I_FEAT = int'(SEL_FEAT);
  localparam int I_CNT  = int'(SEL_COUNT);
  localparam int I_LO   = int'(SEL_LBA_LO);
  localparam int I_MID  = int'(SEL_LBA_MID);
  localparam int I_HI   = int'(SEL_LBA_HI);

  always_comb begin
    if (op == OP_IDENT) begin
      lba   = '0;
      count = CNT_W'(1);
    end else if (ext) begin
      lba   = lba_long(prev[I_HI], prev[I_MID], prev[I_LO],
                       cur[I_HI], cur[I_MID], cur[I_LO]);
      count = count_long(prev[I_CNT], cur[I_CNT]);
    end else begin
      lba   = lba_short(dev_nib, cur[I_HI], cur[I_MID], cur[I_LO]);
      count = count_short(cur[I_CNT]);
    end
    feat = ext ? {prev[I_FEAT], cur[I_FEAT]} : {{BYTE_W{1'b0}}, cur[I_FEAT]};
  end

endmodule

// File: rtl/tfr_cmd_decoder.sv
module tfr_cmd_decoder
  import tfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_strap,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic              cmd_ext,
  output logic [LBA_W-1:0]  cmd_lba,
  output logic [CNT_W-1:0]  cmd_count,
  output logic [FEAT_W-1:0] cmd_feat,
  output logic [BYTE_W-1:0] dev_reg,
  output logic [BYTE_W-1:0] cmd_reg,
  output logic [BYTE_W-1:0] status
);

  logic [NUM_FIFO-1:0][BYTE_W-1:0] fifo_cur;
  logic [NUM_FIFO-1:0][BYTE_W-1:0] fifo_prev;
  logic [BYTE_W-1:0] device_q;
  logic [BYTE_W-1:0] cmd_q;
  logic              err_q;

  // Named internal events, used by the bound checker.
  logic cmd_wr;
  logic dev_match;
  logic cmd_accept;
  logic cmd_reject;
  logic status_err;
  logic [BYTE_W-1:0] lo_cur;
  logic [BYTE_W-1:0] lo_prev;

  assign cmd_wr = wr_en && (wr_sel == SEL_CMD);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIFO; gi++) begin : g_fifo
      tfr_byte_fifo #(.W(BYTE_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (wr_en && (wr_sel == SEL_W'(gi))),
        .din  (wr_data),
        .cur  (fifo_cur[gi]),
        .prev (fifo_prev[gi])
      );
    end
  endgenerate

  assign lo_cur  = fifo_cur[int'(SEL_LBA_LO)];
  assign lo_prev = fifo_prev[int'(SEL_LBA_LO)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      device_q <= '0;
      cmd_q    <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_DEVICE) device_q <= wr_data;
      if (wr_sel == SEL_CMD)    cmd_q    <= wr_data;
    end
  end

  op_e  dec_op;
  logic dec_ext;

  tfr_cmd_decode u_dec (
    .opcode      (wr_data),
    .dev_lba_mode(device_q[DEV_LBA_BIT]),
    .dev_select  (device_q[DEV_SEL_BIT]),
    .dev_strap   (dev_strap),
    .dev_match   (dev_match),
    .accept      (cmd_accept),
    .reject      (cmd_reject),
    .op          (dec_op),
    .ext         (dec_ext)
  );

  logic [LBA_W-1:0]  bld_lba;
  logic [CNT_W-1:0]  bld_count;
  logic [FEAT_W-1:0] bld_feat;

  tfr_addr_build u_addr (
    .cur    (fifo_cur),
    .prev   (fifo_prev),
    .dev_nib(device_q[3:0]),
    .op     (dec_op),
    .ext    (dec_ext),
    .lba    (bld_lba),
    .count  (bld_count),
    .feat   (bld_feat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= 2'(OP_NONE);
      cmd_ext   <= 1'b0;
      cmd_lba   <= '0;
      cmd_count <= '0;
      cmd_feat  <= '0;
      err_q     <= 1'b0;
    end else begin
      cmd_valid <= cmd_wr && cmd_accept;
      if (cmd_wr && cmd_accept) begin
        cmd_op    <= 2'(dec_op);
        cmd_ext   <= dec_ext;
        cmd_lba   <= bld_lba;
        cmd_count <= bld_count;
        cmd_feat  <= bld_feat;
        err_q     <= 1'b0;
      end else if (cmd_wr && cmd_reject) begin
        err_q     <= 1'b1;
      end
    end
  end

  assign status_err = err_q;
  assign status     = {{(BYTE_W-1){1'b0}}, err_q};
  assign dev_reg    = device_q | DEV_FIXED_ONES;
  assign cmd_reg    = cmd_q;

endmodule

// File: rtl/tfr_cmd_decoder_chk.sv
module tfr_cmd_decoder_chk
  import tfr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic              cmd_wr,
  input logic              dev_match,
  input logic              cmd_reject,
  input logic              cmd_valid,
  input logic              status_err,
  input logic [BYTE_W-1:0] lo_cur,
  input logic [BYTE_W-1:0] lo_prev
);

  // R11
  valid_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cmd_wr && dev_match));

  // R8
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_err) |-> $past(cmd_wr && cmd_reject));

  // R8
  valid_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !status_err);

  // R10
  mismatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !dev_match) |=> (!cmd_valid && $stable(status_err)));

  // R2
  fifo_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_LBA_LO) |=> (lo_prev == $past(lo_cur) && lo_cur == $past(wr_data)));

endmodule

bind tfr_cmd_decoder tfr_cmd_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .cmd_wr    (cmd_wr),
  .dev_match (dev_match),
  .cmd_reject(cmd_reject),
  .cmd_valid (cmd_valid),
  .status_err(status_err),
  .lo_cur    (lo_cur),
  .lo_prev   (lo_prev)
);

// File: tb/tfr_cmd_decoder_test.sv
`timescale 1ns/1ps
module tfr_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_strap = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_ext;
  logic [47:0] cmd_lba;
  logic [16:0] cmd_count;
  logic [15:0] cmd_feat;
  logic [7:0]  dev_reg;
  logic [7:0]  cmd_reg;
  logic [7:0]  status;

  always #2 clk = ~clk;

  tfr_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .dev_strap(dev_strap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ext(cmd_ext),
    .cmd_lba(cmd_lba), .cmd_count(cmd_count), .cmd_feat(cmd_feat),
    .dev_reg(dev_reg), .cmd_reg(cmd_reg), .status(status)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench-side model of stored state
  logic [7:0] m_cur [5];
  logic [7:0] m_prev[5];
  logic [7:0] m_dev;
  logic [7:0] m_cmd;
  logic       m_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] exp_lba(input logic [7:0] opc);
    logic [47:0] r = '0;
    if (opc == 8'hEC) return '0;
    if (opc == 8'h24 || opc == 8'h34) begin
      // low byte register first, current bytes below previous bytes
      for (int k = 0; k < 3; k++) begin
        r = r | (48'(m_cur[2+k])  << (8*k));
        r = r | (48'(m_prev[2+k]) << (8*(k+3)));
      end
    end else begin
      for (int k = 0; k < 3; k++) r = r | (48'(m_cur[2+k]) << (8*k));
      r = r | (48'(m_dev & 8'h0F) << 24);
    end
    return r;
  endfunction

  function automatic logic [16:0] exp_cnt(input logic [7:0] opc);
    int v;
    if (opc == 8'hEC) return 17'd1;
    if (opc == 8'h24 || opc == 8'h34) begin
      v = m_prev[1] * 256 + m_cur[1];
      if (v == 0) v = 65536;
    end else begin
      v = m_cur[1];
      if (v == 0) v = 256;
    end
    return 17'(v);
  endfunction

  task automatic write_reg(input logic [2:0] sel, input logic [7:0] data);
    bit known, ext, lba_need, match, exp_v;
    logic [1:0] e_op;
    string tag;
    known = 1'b1; ext = 1'b0; lba_need = 1'b1; e_op = 2'd0;
    case (data)
      8'h20: e_op = 2'd1;
      8'h24: begin e_op = 2'd1; ext = 1'b1; end
      8'h30: e_op = 2'd2;
      8'h34: begin e_op = 2'd2; ext = 1'b1; end
      8'hEC: begin e_op = 2'd3; lba_need = 1'b0; end
      default: known = 1'b0;
    endcase
    match = (m_dev[4] == dev_strap);
    exp_v = 1'b0;
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 3'd6) begin
      m_cmd = data;
      if (!match) tag = "R10";
      else if (!known) begin tag = "R8"; m_err = 1'b1; end
      else if (lba_need && !m_dev[6]) begin tag = "R9"; m_err = 1'b1; end
      else begin tag = "R11"; exp_v = 1'b1; m_err = 1'b0; end
      chk(cmd_valid == exp_v, tag, "cmd_valid", 64'(cmd_valid), 64'(exp_v));
      chk(status == {7'd0, m_err}, tag, "status", 64'(status), 64'({7'd0, m_err}));
      chk(cmd_reg == m_cmd, "R10", "cmd_reg", 64'(cmd_reg), 64'(m_cmd));
      if (exp_v) begin
        chk(cmd_op == e_op && cmd_ext == ext, "R5", "op/ext",
            64'({cmd_op, cmd_ext}), 64'({e_op, ext}));
        chk(cmd_lba == exp_lba(data), ext ? "R3" : "R4", "lba",
            64'(cmd_lba), 64'(exp_lba(data)));
        chk(cmd_count == exp_cnt(data), "R6", "count",
            64'(cmd_count), 64'(exp_cnt(data)));
        chk(cmd_feat == (ext ? {m_prev[0], m_cur[0]} : {8'd0, m_cur[0]}), "R7",
            "feat", 64'(cmd_feat), 64'(ext ? {m_prev[0], m_cur[0]} : {8'd0, m_cur[0]}));
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R11", "pulse width", 64'(cmd_valid), 64'd0);
      end
    end else begin
      if (sel < 3'd5) begin
        m_prev[sel] = m_cur[sel];
        m_cur[sel]  = data;
      end else if (sel == 3'd5) m_dev = data;
      chk(cmd_valid == 1'b0, "R2", "no pulse on data write", 64'(cmd_valid), 64'd0);
      chk(dev_reg == (m_dev | 8'hA0), "R12", "dev_reg",
          64'(dev_reg), 64'(m_dev | 8'hA0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 5; i++) begin m_cur[i] = 8'd0; m_prev[i] = 8'd0; end
    m_dev = 8'd0; m_cmd = 8'd0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_valid == 1'b0, "R1", "cmd_valid", 64'(cmd_valid), 64'd0);
    chk(status == 8'h00, "R1", "status", 64'(status), 64'h00);
    chk(dev_reg == 8'hA0, "R1", "dev_reg", 64'(dev_reg), 64'hA0);
    chk(cmd_reg == 8'h00, "R1", "cmd_reg", 64'(cmd_reg), 64'h00);
    write_reg(3'd5, 8'h40);
    write_reg(3'd6, 8'h24);            // R1: zero address, count 65536
    chk(cmd_lba == 48'd0 && cmd_count == 17'h10000, "R1", "post-reset long read",
        64'({cmd_lba, cmd_count[15:0]}), 64'd0);

    // R3 worked example
    write_reg(3'd2, 8'h56); write_reg(3'd2, 8'hEF);
    write_reg(3'd3, 8'h34); write_reg(3'd3, 8'hCD);
    write_reg(3'd4, 8'h12); write_reg(3'd4, 8'hAB);
    write_reg(3'd6, 8'h24);
    chk(cmd_lba == 48'h123456ABCDEF, "R3", "example address",
        64'(cmd_lba), 64'h123456ABCDEF);
    // R4 short address with device nibble, R6 zero count = 256
    write_reg(3'd5, 8'h4A);
    write_reg(3'd6, 8'h20);
    chk(cmd_lba == 48'h0AABCDEF && cmd_count == 17'd256, "R4", "short addr/count",
        64'({cmd_lba, cmd_count}), 64'({48'h0AABCDEF, 17'd256}));
    // R6/R7 long count and features
    write_reg(3'd1, 8'h01); write_reg(3'd1, 8'h02);
    write_reg(3'd0, 8'h11); write_reg(3'd0, 8'h22);
    write_reg(3'd6, 8'h34);
    write_reg(3'd6, 8'h30);
    write_reg(3'd6, 8'hEC);
    // R8 unsupported opcode then recovery
    write_reg(3'd6, 8'h99);
    write_reg(3'd6, 8'h20);
    // R9 LBA bit clear
    write_reg(3'd5, 8'h0F);
    write_reg(3'd6, 8'h30);
    write_reg(3'd6, 8'hEC);
    // R10 other device: ignored, then state shown unchanged
    write_reg(3'd5, 8'h40);
    write_reg(3'd6, 8'h55);
    write_reg(3'd5, 8'h50);
    write_reg(3'd6, 8'h24);
    write_reg(3'd6, 8'h77);
    write_reg(3'd5, 8'h40);
    write_reg(3'd6, 8'h24);
    // R12 select 7 ignored
    write_reg(3'd7, 8'hFF);
    write_reg(3'd6, 8'h24);

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [2:0] s;
      logic [7:0] d;
      int pick;
      if (i == 300) dev_strap = 1'b1;
      s = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (s == 3'd5 && $urandom_range(0, 3) != 0) d[6] = 1'b1;
      if (s == 3'd5 && $urandom_range(0, 3) != 0) d[4] = dev_strap;
      if (s == 3'd6) begin
        pick = $urandom_range(0, 5);
        case (pick)
          0: d = 8'h20; 1: d = 8'h24; 2: d = 8'h30;
          3: d = 8'h34; 4: d = 8'hEC; default: ;
        endcase
      end
      write_reg(s, d);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule